// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a clocked host and an asynchronous static memory that has both a data array and a separate semaphore space. Each host request carries an address, an 18-bit word, two byte-lane enables, a target select and a timing-style select. The block turns that request into a timed pin sequence on the memory side. The sequence drives the address, the two chip-enable pins, the semaphore select, read/write, the byte lanes, output enable and the tri-state enable of the data bus. When the memory's recovery time has passed, the block pulses `done_o`.

Every interval is a parameter counted in clock cycles, and each must be at least one. The host picks one of two write styles. In the read/write-timed style, read/write is the last strobe to fall and the first to rise. In the enable-timed style, the array or semaphore enable plays that role. When the host keeps output enable low during a read/write-timed write, the memory may still be driving the bus. In that case the block waits a turnaround interval before it drives data, and it stretches the write pulse to match.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset and whenever idle: `mem_ce0_no`=1, `mem_ce1_o`=0, `mem_sem_no`=1, `mem_rw_no`=1, `mem_be_no`=2'b11, `mem_oe_no`=1, `mem_dq_oe_o`=0, `busy_o`=0, `done_o`=0.
- R2: The active enable strobe depends on `sem_sel_i`. For the array (`sem_sel_i`=0) it is `mem_ce0_no`=0, `mem_ce1_o`=1, `mem_sem_no`=1. For the semaphore (`sem_sel_i`=1) it is `mem_ce0_no`=1, `mem_ce1_o`=0, `mem_sem_no`=0. The two spaces are never selected together.
- R3: The write overlap is the span during which the enable strobe is active and `mem_rw_no`=0. It lasts PL cycles, where PL = max(T_WP, TURN+T_DW). TURN is T_WZ when `mode_i`=0 and `oe_keep_i`=1, and 0 otherwise.
- R4: Take cycle 0 as the first cycle after the request is accepted. With `mode_i`=0, the enable strobe is active in cycles [0, T_AS+PL+T_DH) and `mem_rw_no` is low in [T_AS, T_AS+PL). With `mode_i`=1 the two windows are swapped.
- R5: `mem_addr_o` shows the accepted address from cycle 0 until the next accepted request. It never changes between two consecutive overlap cycles. Each `mem_be_no[k]` equals the inverse of `be_i[k]` (bit 1 upper, bit 0 lower) in cycles [0, T_AS+PL+T_DH), and is 1 at all other times.
- R6: `mem_dq_oe_o` is high exactly in cycles [T_AS+TURN, T_AS+PL+T_DH). While it is high, `mem_dq_o` equals the accepted data word.
- R7: If `oe_keep_i`=1, `mem_oe_no` is low in cycles [0, T_AS+PL+T_DH). If `oe_keep_i`=0, it stays high throughout.
- R8: `busy_o` is high in cycles [0, LAT], where LAT = T_AS+PL+T_DH+T_WR. `done_o` is high only in cycle LAT.
- R9: Requests made while `busy_o` is high are ignored. They alter no memory pin, and no further write follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a write, taken when idle |
| mode_i | input | 1 | 0: read/write-timed, 1: enable-timed |
| oe_keep_i | input | 1 | Hold memory output enable low during the write |
| sem_sel_i | input | 1 | 0: data array, 1: semaphore space |
| be_i | input | 2 | Byte-lane enables, bit 1 upper, bit 0 lower |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce0_no | output | 1 | First chip enable, active low |
| mem_ce1_o | output | 1 | Second chip enable, active high |
| mem_sem_no | output | 1 | Semaphore select, active low |
| mem_rw_no | output | 1 | Read/write, low writes |
| mem_be_no | output | 2 | Byte lanes, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data toward the bus |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The bench sweeps every combination of write style, output-enable hold, target space and byte-lane pattern. It compares each pin against per-cycle windows that it derives from the interval parameters. An off-by-one in the stretched pulse would move the overlap length or the first data-drive cycle, so the bench checks both. Driving data before the turnaround would cause bus contention with the memory's own outputs, and swapping the strobe order would leave the wrong strobe defining the pulse edges; the cycle-by-cycle strobe windows catch each of these. Requests are injected mid-write and in the done cycle, so a design that re-arms early would move the address or start a second sequence.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RECOV,
    ST_DONE
  } wr_state_e;

  function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_len.sv
`timescale 1ns/1ps
module sram_wr_len
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_WP = 3,
  parameter int unsigned T_WZ = 2,
  parameter int unsigned T_DW = 2,
  parameter int unsigned CW   = 4
) (
  input  logic          mode_ce_i,
  input  logic          oe_keep_i,
  output logic [CW-1:0] pulse_len_o,
  output logic [CW-1:0] turn_o
);

  localparam int unsigned PL_TURN   = maxu(T_WP, T_WZ + T_DW);
  localparam int unsigned PL_DIRECT = maxu(T_WP, T_DW);

  logic need_turn;

  // memory outputs only go active when enable falls while read/write is high
  assign need_turn = !mode_ce_i && oe_keep_i;

  always_comb begin
    if (need_turn) begin
      pulse_len_o = CW'(PL_TURN);
      turn_o      = CW'(T_WZ);
    end else begin
      pulse_len_o = CW'(PL_DIRECT);
      turn_o      = '0;
    end
  end

endmodule

// File: rtl/sram_wr_timer.sv
`timescale 1ns/1ps
module sram_wr_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] cnt_d_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  assign last_o  = run_i && (cnt_q == len_i - CW'(1));
  assign cnt_d_o = (!run_i || last_o) ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

endmodule

// File: rtl/sram_wr_pins.sv
`timescale 1ns/1ps
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  wr_state_e        state_i,
  input  logic             mode_ce_i,
  input  logic             sem_i,
  input  logic             oe_keep_i,
  input  logic             dq_en_i,
  input  logic [LANES-1:0] be_i,
  output logic             ce0_n_o,
  output logic             ce1_o,
  output logic             sem_n_o,
  output logic             rw_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o,
  output logic [LANES-1:0] be_n_o
);

  logic win, pulse, en_act, rw_act;

  assign win   = (state_i == ST_SETUP) || (state_i == ST_PULSE) || (state_i == ST_HOLD);
  assign pulse = (state_i == ST_PULSE);

  // selected strobe covers only the pulse; the other spans setup..hold
  assign en_act = mode_ce_i ? pulse : win;
  assign rw_act = mode_ce_i ? win   : pulse;

  assign ce0_n_o = !(en_act && !sem_i);
  assign ce1_o   =   en_act && !sem_i;
  assign sem_n_o = !(en_act &&  sem_i);
  assign rw_n_o  = !rw_act;
  assign oe_n_o  = !(win && oe_keep_i);
  assign dq_oe_o = dq_en_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n_o[g] = !(win && be_i[g]);
  end

endmodule

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_WZ   = 2,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              mode_i,
  input  logic              oe_keep_i,
  input  logic              sem_sel_i,
  input  logic [1:0]        be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce0_no,
  output logic              mem_ce1_o,
  output logic              mem_sem_no,
  output logic              mem_rw_no,
  output logic [1:0]        mem_be_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  localparam int unsigned LANES = 2;
  localparam int unsigned MAXL  = maxu(maxu(T_AS, maxu(T_WP, T_WZ + T_DW)), maxu(T_DH, T_WR));
  localparam int unsigned CW    = $clog2(MAXL + 1) + 1;

  wr_state_e         state_q, state_d;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  be_q;
  logic              sem_q, mode_q, oe_q;

  logic [CW-1:0]     pulse_len, turn, len_cur, cnt_d;
  logic              last, dq_en_d;

  logic              ce0_n_d, ce1_d, sem_n_d, rw_n_d, oe_n_d, dq_oe_d;
  logic [LANES-1:0]  be_n_d;

  sram_wr_len #(
    .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW), .CW(CW)
  ) i_len (
    .mode_ce_i  (mode_q),
    .oe_keep_i  (oe_q),
    .pulse_len_o(pulse_len),
    .turn_o     (turn)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP: len_cur = CW'(T_AS);
      ST_PULSE: len_cur = pulse_len;
      ST_HOLD:  len_cur = CW'(T_DH);
      ST_RECOV: len_cur = CW'(T_WR);
      default:  len_cur = CW'(1);
    endcase
  end

  sram_wr_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .len_i  (len_cur),
    .cnt_d_o(cnt_d),
    .last_o (last)
  );

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SETUP;
      ST_SETUP: if (last)   state_d = ST_PULSE;
      ST_PULSE: if (last)   state_d = ST_HOLD;
      ST_HOLD:  if (last)   state_d = ST_RECOV;
      ST_RECOV: if (last)   state_d = ST_DONE;
      ST_DONE:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  // turnaround wait inside the pulse before data goes on the bus
  assign dq_en_d = ((state_d == ST_PULSE) && (cnt_d >= turn)) || (state_d == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      sem_q   <= 1'b0;
      mode_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_i;
        data_q <= data_i;
        be_q   <= be_i;
        sem_q  <= sem_sel_i;
        mode_q <= mode_i;
        oe_q   <= oe_keep_i;
      end
    end
  end

  // pin levels decoded from the next state, then registered
  sram_wr_pins #(.LANES(LANES)) i_pins (
    .state_i  (state_d),
    .mode_ce_i(accept ? mode_i    : mode_q),
    .sem_i    (accept ? sem_sel_i : sem_q),
    .oe_keep_i(accept ? oe_keep_i : oe_q),
    .dq_en_i  (dq_en_d),
    .be_i     (accept ? be_i      : be_q),
    .ce0_n_o  (ce0_n_d),
    .ce1_o    (ce1_d),
    .sem_n_o  (sem_n_d),
    .rw_n_o   (rw_n_d),
    .oe_n_o   (oe_n_d),
    .dq_oe_o  (dq_oe_d),
    .be_n_o   (be_n_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce0_no  <= 1'b1;
      mem_ce1_o   <= 1'b0;
      mem_sem_no  <= 1'b1;
      mem_rw_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      mem_be_no   <= '1;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      mem_ce0_no  <= ce0_n_d;
      mem_ce1_o   <= ce1_d;
      mem_sem_no  <= sem_n_d;
      mem_rw_no   <= rw_n_d;
      mem_oe_no   <= oe_n_d;
      mem_dq_oe_o <= dq_oe_d;
      mem_be_no   <= be_n_d;
      busy_o      <= (state_d != ST_IDLE);
      done_o      <= (state_d == ST_DONE);
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = data_q;

endmodule

// File: rtl/sram_wr_seq_chk.sv
`timescale 1ns/1ps
module sram_wr_seq_chk
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_WZ   = 2,
  parameter int unsigned T_DW   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce0_no,
  input logic              mem_ce1_o,
  input logic              mem_sem_no,
  input logic              mem_rw_no,
  input logic              mem_dq_oe_o
);

  localparam int unsigned PL_MAX = maxu(T_WP, T_WZ + T_DW);

  logic        ovl;
  logic [15:0] ovl_run;

  assign ovl = ((!mem_ce0_no && mem_ce1_o) || !mem_sem_no) && !mem_rw_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ovl_run <= '0;
    else if (ovl) ovl_run <= ovl_run + 16'd1;
    else          ovl_run <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_rw_no && mem_sem_no && mem_ce0_no && !mem_ce1_o && !mem_dq_oe_o));

  a_r2_one_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((!mem_ce0_no && mem_ce1_o) && !mem_sem_no));

  a_r3_pulse_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_run <= 16'(PL_MAX));

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl && $past(ovl)) |-> $stable(mem_addr_o));

  a_r6_dq_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> ovl);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .ADDR_W(ADDR_W), .T_WP(T_WP), .T_WZ(T_WZ), .T_DW(T_DW)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce0_no (mem_ce0_no),
  .mem_ce1_o  (mem_ce1_o),
  .mem_sem_no (mem_sem_no),
  .mem_rw_no  (mem_rw_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/test_sram_wr_seq.sv
`timescale 1ns/1ps
module test_sram_wr_seq;

  localparam int AW   = 6;
  localparam int DW   = 18;
  localparam int T_AS = 2;
  localparam int T_WP = 3;
  localparam int T_WZ = 2;
  localparam int T_DW = 2;
  localparam int T_DH = 1;
  localparam int T_WR = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, mode_i = 1'b0, oe_keep_i = 1'b0, sem_sel_i = 1'b0;
  logic [1:0]    be_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          busy_o, done_o, mem_ce0_no, mem_ce1_o, mem_sem_no, mem_rw_no;
  logic          mem_oe_no, mem_dq_oe_o;
  logic [1:0]    mem_be_no;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_dq_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  sram_wr_seq #(
    .ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
    .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)
  ) i_sram_wr_seq (
    .clk_i, .rst_ni, .req_i, .mode_i, .oe_keep_i, .sem_sel_i, .be_i, .addr_i,
    .data_i, .busy_o, .done_o, .mem_addr_o, .mem_ce0_no, .mem_ce1_o,
    .mem_sem_no, .mem_rw_no, .mem_be_no, .mem_oe_no, .mem_dq_o, .mem_dq_oe_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int enc(input bit en, input bit sem);
    if (!en)     return 3'b101; // {ce0_n, ce1, sem_n}
    else if (sem) return 3'b100;
    else          return 3'b011;
  endfunction

  task automatic do_write(input bit md, input bit oe, input bit sm, input logic [1:0] be,
                          input logic [AW-1:0] ad, input logic [DW-1:0] dt);
    int turn, pl, win_end, lat, ovl_n;
    bit done_seen;
    bit exp_en, exp_rw, sel_on, exp_win, exp_dq, en_now;
    turn    = (!md && oe) ? T_WZ : 0;
    pl      = (T_WP > turn + T_DW) ? T_WP : turn + T_DW;
    win_end = T_AS + pl + T_DH;
    lat     = win_end + T_WR;
    ovl_n   = 0;
    done_seen = 1'b0;
    @(negedge clk_i);
    req_i = 1'b1; mode_i = md; oe_keep_i = oe; sem_sel_i = sm; be_i = be;
    addr_i = ad; data_i = dt;
    for (int i = 0; i <= lat + 3; i++) begin
      @(negedge clk_i);
      exp_win = (i < win_end);
      sel_on  = (i >= T_AS) && (i < T_AS + pl);
      exp_en  = md ? sel_on : exp_win;
      exp_rw  = md ? exp_win : sel_on;
      exp_dq  = (i >= T_AS + turn) && exp_win;
      en_now  = sm ? !mem_sem_no : (!mem_ce0_no && mem_ce1_o);
      if (en_now && !mem_rw_no) ovl_n++;
      // R2 / R4: enable pins and encoding per cycle
      chk({mem_ce0_no, mem_ce1_o, mem_sem_no} == 3'(enc(exp_en, sm)), "R2_R4 enable",
          int'({mem_ce0_no, mem_ce1_o, mem_sem_no}), enc(exp_en, sm));
      chk(mem_rw_no == !exp_rw, "R4 rw", int'(mem_rw_no), int'(!exp_rw));
      chk(mem_addr_o == ad, "R5 addr", int'(mem_addr_o), int'(ad));
      chk(mem_be_no == (exp_win ? ~be : 2'b11), "R5 lanes", int'(mem_be_no),
          int'(exp_win ? ~be : 2'b11));
      chk(mem_dq_oe_o == exp_dq, "R6 dq_oe", int'(mem_dq_oe_o), int'(exp_dq));
      if (mem_dq_oe_o) chk(mem_dq_o == dt, "R6 data", int'(mem_dq_o), int'(dt));
      chk(mem_oe_no == !(exp_win && oe), "R7 oe", int'(mem_oe_no), int'(!(exp_win && oe)));
      chk(busy_o == (i <= lat), "R8 busy", int'(busy_o), int'(i <= lat));
      chk(done_o == (i == lat), "R8 done", int'(done_o), int'(i == lat));
      if (done_o) done_seen = 1'b1;
      if (i > lat) chk(mem_rw_no && !busy_o, "R9 no rearm", int'({mem_rw_no, busy_o}), 2);
      // R9 stimulus: requests while busy, different address and data
      if (i == 3 || i == lat) begin
        req_i = 1'b1; addr_i = ~ad; data_i = ~dt; mode_i = !md; sem_sel_i = !sm;
      end else begin
        req_i = 1'b0;
      end
    end
    chk(ovl_n == pl, "R3 overlap", ovl_n, pl);
    chk(done_seen, "R8 done seen", int'(done_seen), 1);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset levels
    chk({mem_ce0_no, mem_ce1_o, mem_sem_no, mem_rw_no} == 4'b1011, "R1 strobes",
        int'({mem_ce0_no, mem_ce1_o, mem_sem_no, mem_rw_no}), 4'b1011);
    chk(mem_be_no == 2'b11 && mem_oe_no, "R1 lanes oe", int'({mem_be_no, mem_oe_no}), 3'b111);
    chk(!mem_dq_oe_o && !busy_o && !done_o, "R1 bus idle",
        int'({mem_dq_oe_o, busy_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(mem_rw_no && !busy_o, "R1 idle after reset", int'({mem_rw_no, busy_o}), 2);
    for (int k = 0; k < 32; k++) begin
      do_write(k[4], k[3], k[2], k[1:0], AW'(k * 5 + 3), DW'(k * 12345 + 7));
    end
    summary();
  end

endmodule